// File: doc/BRIEF.md
# Segment Operand Access Fault Checker

This block decides whether one memory operand reference is allowed by the segment it goes through. If it is not, the block picks the exception vector to report. A request gives the operating mode, the segment register in use, the operand's starting offset, its size in bytes, and the segment's limit. It also gives two descriptor flags: present and rights-ok. The block works out the address of the operand's last byte and compares the whole extent against the limit that applies. It then reports either no fault or one vector.

The vector depends on the segment register. A stack segment fault always reports vector 12. Any other segment reports vector 11 when the segment is absent and vector 13 for a rights or limit problem. In real mode the limit input is replaced by a fixed ceiling of FFFFh. Descriptor fetch, granularity scaling, expand-down segments and address translation are done elsewhere. This block only makes the fault decision and selects the vector.

A request is one cycle with `req_valid` high. The registered result appears on the next cycle with `done` high. Between requests the result outputs keep their last values.

Top module: `seg_fault_checker`

## Requirements
- R1: While `rst` is high, and after it is released with no request, `done`, `fault` and `size_err` are 0 and `vector` is 0.
- R2: A request on `req_valid` gives `done`=1 on the next cycle, with the result for that request. With `req_valid` low, `done` is 0 on the next cycle and `fault`, `vector` and `size_err` keep their values.
- R3: The legal values of `size` are 1, 2, 4 and 8. Any other value gives `size_err`=1, `fault`=0 and `vector`=0. This outcome overrides every other condition.
- R4: The check uses the operand's last byte, offset + size - 1, computed one bit wider than the offset. An operand that only partly crosses the limit faults. An extent that wraps past the top of the offset space counts as a limit violation.
- R5: In real mode (`mode`=0) the ceiling is FFFFh, whatever the `limit` input says. `present` and `rights_ok` are ignored. If the last byte is above FFFFh through a non-stack segment, the result is vector 13.
- R6: In real mode, if the last byte is above FFFFh through SS (`seg_sel`=5), the result is vector 12.
- R7: In protected mode (`mode`=1), if the last byte is above `limit`, the result is vector 12 for SS and vector 13 for any other segment.
- R8: In protected mode, `rights_ok`=0 gives vector 12 for SS and vector 13 for any other segment.
- R9: In protected mode, `present`=0 gives vector 12 for SS and vector 11 for any other segment.
- R10: When several protected-mode conditions hold, only one vector is reported. Absence comes first, then rights, then limit. For example, an absent segment with bad rights and an overrun on DS gives vector 11.
- R11: A request with no fault gives `fault`=0 and `vector`=0. The `seg_sel` codes are CS=0, DS=1, ES=2, FS=3, GS=4 and SS=5. Codes 6 and 7 are handled as non-stack segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Starts one check this cycle |
| mode | input | 1 | 0 real, 1 protected |
| seg_sel | input | 3 | Segment register code (SS=5) |
| offset | input | 32 | Operand starting offset |
| size | input | 4 | Operand size in bytes |
| limit | input | 32 | Segment limit (protected mode only) |
| present | input | 1 | Descriptor present flag |
| rights_ok | input | 1 | Access rights allow the reference |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | A fault was found |
| vector | output | 8 | Exception vector: 11, 12, 13, or 0 |
| size_err | output | 1 | Request had an illegal size |

## Verification
The bench places operands so that the last byte sits exactly on the limit and exactly one byte past it. A design that checked only the first byte, or used `>=`, would get one of these two cases wrong. It drives protected-mode extents that wrap past FFFFFFFFh. A design without the carry bit would see a small last-byte address and report no fault. It also sends real-mode requests with a zero limit and bad flags to catch designs that use those inputs in real mode. Finally, it combines absence, bad rights and overrun on both stack and non-stack segments. A wrong priority or a wrong stack mapping then shows up as vector 13 where 11 or 12 is expected.

// File: rtl/seg_fault_pkg.sv
package seg_fault_pkg;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } op_mode_e;

    localparam logic [2:0] SEG_SS = 3'd5;

    localparam logic [7:0] VEC_NONE   = 8'd0;
    localparam logic [7:0] VEC_ABSENT = 8'd11;
    localparam logic [7:0] VEC_STACK  = 8'd12;
    localparam logic [7:0] VEC_GP     = 8'd13;

    typedef struct packed {
        logic       size_err;
        logic       fault;
        logic [7:0] vector;
    } chk_result_t;

    function automatic logic legal_size(input logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction

    function automatic logic [7:0] pick_vector(input logic is_stack, input logic absent);
        if (is_stack) return VEC_STACK;
        if (absent)   return VEC_ABSENT;
        return VEC_GP;
    endfunction

endpackage

// File: rtl/seg_extent_calc.sv
module seg_extent_calc
    import seg_fault_pkg::*;
#(
    parameter int OFS_W = 32,
    parameter int SZ_W  = 4
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [SZ_W-1:0]  size,
    output logic [OFS_W:0]   last_byte,
    output logic             size_ok
);
    localparam int EXT_W = OFS_W + 1;

    always_comb begin
        size_ok   = legal_size(size);
        last_byte = {1'b0, offset} + EXT_W'(size) - EXT_W'(1);
    end

endmodule

// File: rtl/seg_fault_classify.sv
module seg_fault_classify
    import seg_fault_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  op_mode_e          mode,
    input  logic [2:0]        seg_sel,
    input  logic [OFS_W:0]    last_byte,
    input  logic              size_ok,
    input  logic [OFS_W-1:0]  limit,
    input  logic              present,
    input  logic              rights_ok,
    output chk_result_t       result
);
    localparam int          EXT_W     = OFS_W + 1;
    localparam logic [EXT_W-1:0] REAL_CEIL = EXT_W'(17'h0FFFF);

    logic             is_stack;
    logic [EXT_W-1:0] eff_limit;
    logic             over_limit;
    logic             absent;
    logic             bad_rights;

    always_comb begin
        is_stack   = (seg_sel == SEG_SS);
        eff_limit  = (mode == MODE_REAL) ? REAL_CEIL : {1'b0, limit};
        over_limit = last_byte > eff_limit;
        absent     = (mode == MODE_PROT) && !present;
        bad_rights = (mode == MODE_PROT) && !rights_ok;

        result = '{size_err: 1'b0, fault: 1'b0, vector: VEC_NONE};
        if (!size_ok) begin
            result.size_err = 1'b1;
        end else if (absent) begin
            result.fault  = 1'b1;
            result.vector = pick_vector(is_stack, 1'b1);
        end else if (bad_rights || over_limit) begin
            result.fault  = 1'b1;
            result.vector = pick_vector(is_stack, 1'b0);
        end
    end

endmodule

// File: rtl/seg_fault_checker.sv
module seg_fault_checker
    import seg_fault_pkg::*;
#(
    parameter int OFS_W = 32,
    parameter int SZ_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             mode,
    input  logic [2:0]       seg_sel,
    input  logic [OFS_W-1:0] offset,
    input  logic [SZ_W-1:0]  size,
    input  logic [OFS_W-1:0] limit,
    input  logic             present,
    input  logic             rights_ok,
    output logic             done,
    output logic             fault,
    output logic [7:0]       vector,
    output logic             size_err
);
    logic [OFS_W:0] last_byte;
    logic           size_ok;
    chk_result_t    comb_res;
    chk_result_t    res_q;
    logic           done_q;

    seg_extent_calc #(.OFS_W(OFS_W), .SZ_W(SZ_W)) u_extent (
        .offset   (offset),
        .size     (size),
        .last_byte(last_byte),
        .size_ok  (size_ok)
    );

    seg_fault_classify #(.OFS_W(OFS_W)) u_classify (
        .mode     (op_mode_e'(mode)),
        .seg_sel  (seg_sel),
        .last_byte(last_byte),
        .size_ok  (size_ok),
        .limit    (limit),
        .present  (present),
        .rights_ok(rights_ok),
        .result   (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            res_q  <= '{size_err: 1'b0, fault: 1'b0, vector: VEC_NONE};
        end else begin
            done_q <= req_valid;
            if (req_valid) res_q <= comb_res;
        end
    end

    assign done     = done_q;
    assign fault    = res_q.fault;
    assign vector   = res_q.vector;
    assign size_err = res_q.size_err;

    assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done);
    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done);
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(vector) && $stable(fault) && $stable(size_err)));
    assert_size_err_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        size_err |-> (!fault && vector == VEC_NONE));
    assert_bad_size_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(size == 1 || size == 2 || size == 4 || size == 8)) |=> size_err);
    assert_vec_legal_R11: assert property (@(posedge clk) disable iff (rst)
        fault |-> (vector == VEC_ABSENT || vector == VEC_STACK || vector == VEC_GP));
    assert_no_fault_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !fault |-> (vector == VEC_NONE));
    assert_stack_vec_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seg_sel == SEG_SS) |=> (!fault || vector == VEC_STACK));
    assert_absent_first_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode && !present && seg_sel != SEG_SS && size_ok) |=> (vector == VEC_ABSENT));

endmodule

// File: tb/seg_fault_checker_test.sv
module seg_fault_checker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        mode;
    logic [2:0]  seg_sel;
    logic [31:0] offset;
    logic [3:0]  size;
    logic [31:0] limit;
    logic        present;
    logic        rights_ok;
    logic        done;
    logic        fault;
    logic [7:0]  vector;
    logic        size_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seg_fault_checker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .seg_sel(seg_sel), .offset(offset), .size(size), .limit(limit),
        .present(present), .rights_ok(rights_ok), .done(done),
        .fault(fault), .vector(vector), .size_err(size_err)
    );

    // {size_err, fault, vector}
    function automatic logic [9:0] expect_res(input logic m, input logic [2:0] s,
            input logic [31:0] ofs, input logic [3:0] sz, input logic [31:0] lim,
            input logic p, input logic r);
        longint last;
        longint ceil;
        bit stk;
        if (!(sz == 1 || sz == 2 || sz == 4 || sz == 8)) return {1'b1, 1'b0, 8'd0};
        stk  = (s == 3'd5);
        last = longint'(ofs) + longint'(sz) - 1;
        ceil = m ? longint'(lim) : 64'hFFFF;
        if (m && !p)       return {1'b0, 1'b1, stk ? 8'd12 : 8'd11};
        if (m && !r)       return {1'b0, 1'b1, stk ? 8'd12 : 8'd13};
        if (last > ceil)   return {1'b0, 1'b1, stk ? 8'd12 : 8'd13};
        return {1'b0, 1'b0, 8'd0};
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic m, input logic [2:0] s,
            input logic [31:0] ofs, input logic [3:0] sz, input logic [31:0] lim,
            input logic p, input logic r);
        logic [9:0] exp;
        logic [9:0] got;
        exp = expect_res(m, s, ofs, sz, lim, p, r);
        req_valid = 1'b1; mode = m; seg_sel = s; offset = ofs;
        size = sz; limit = lim; present = p; rights_ok = r;
        @(negedge clk);
        check({tag, " R2 done"}, {9'd0, done}, 10'd1);
        got = {size_err, fault, vector};
        check(tag, got, exp);
        req_valid = 1'b0;
        offset = ~ofs; size = 4'd3; present = ~p;
        @(negedge clk);
        check({tag, " R2 idle done"}, {9'd0, done}, 10'd0);
        check({tag, " R2 hold"}, {size_err, fault, vector}, got);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; mode = 1'b0; seg_sel = 3'd0; offset = '0;
        size = 4'd1; limit = '0; present = 1'b1; rights_ok = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", {size_err, fault, vector}, 10'd0);
        check("R1 reset done", {9'd0, done}, 10'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {done, size_err, fault, vector[6:0]}, 10'd0);

        run("R5 R11 real edge ok",        1'b0, 3'd1, 32'h0000FFFE, 4'd2, 32'h0, 1'b0, 1'b0);
        run("R5 R4 real partial",         1'b0, 3'd1, 32'h0000FFFF, 4'd2, 32'hFFFFFFFF, 1'b1, 1'b1);
        run("R5 real cs far",             1'b0, 3'd0, 32'h00012340, 4'd1, 32'hFFFFFFFF, 1'b1, 1'b1);
        run("R6 real ss partial",         1'b0, 3'd5, 32'h0000FFFD, 4'd4, 32'hFFFFFFFF, 1'b1, 1'b1);
        run("R6 real ss ok",              1'b0, 3'd5, 32'h0000FFF8, 4'd8, 32'h0, 1'b1, 1'b1);
        run("R7 R11 prot on limit",       1'b1, 3'd0, 32'h00000100, 4'd4, 32'h00000103, 1'b1, 1'b1);
        run("R7 R4 prot one past",        1'b1, 3'd0, 32'h00000101, 4'd4, 32'h00000103, 1'b1, 1'b1);
        run("R7 prot ss over",            1'b1, 3'd5, 32'h00002000, 4'd8, 32'h00002003, 1'b1, 1'b1);
        run("R7 prot above 64K ok",       1'b1, 3'd3, 32'h00120000, 4'd2, 32'h00200000, 1'b1, 1'b1);
        run("R4 prot wrap",               1'b1, 3'd2, 32'hFFFFFFFE, 4'd4, 32'hFFFFFFFF, 1'b1, 1'b1);
        run("R4 prot top ok",             1'b1, 3'd2, 32'hFFFFFFFC, 4'd4, 32'hFFFFFFFF, 1'b1, 1'b1);
        run("R8 prot rights ds",          1'b1, 3'd1, 32'h00000010, 4'd1, 32'h00001000, 1'b1, 1'b0);
        run("R8 prot rights ss",          1'b1, 3'd5, 32'h00000010, 4'd1, 32'h00001000, 1'b1, 1'b0);
        run("R9 prot absent gs",          1'b1, 3'd4, 32'h00000010, 4'd2, 32'h00001000, 1'b0, 1'b1);
        run("R9 prot absent ss",          1'b1, 3'd5, 32'h00000010, 4'd2, 32'h00001000, 1'b0, 1'b1);
        run("R10 absent beats all",       1'b1, 3'd1, 32'h00002000, 4'd8, 32'h00000010, 1'b0, 1'b0);
        run("R10 rights beats limit ss",  1'b1, 3'd5, 32'h00002000, 4'd8, 32'h00000010, 1'b1, 1'b0);
        run("R3 size 3",                  1'b1, 3'd1, 32'h00002000, 4'd3, 32'h00000010, 1'b0, 1'b0);
        run("R3 size 0",                  1'b0, 3'd5, 32'h0000FFFF, 4'd0, 32'h0, 1'b1, 1'b1);
        run("R3 size 9",                  1'b1, 3'd0, 32'h0, 4'd9, 32'h10, 1'b1, 1'b1);
        run("R3 size 8 legal",            1'b1, 3'd0, 32'h8, 4'd8, 32'h0F, 1'b1, 1'b1);
        run("R11 code 7 nonstack",        1'b1, 3'd7, 32'h00000020, 4'd1, 32'h00000010, 1'b1, 1'b1);

        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] lim;
            logic [31:0] ofs;
            logic [3:0]  sz;
            logic        m;
            m   = 1'($urandom);
            lim = ($urandom % 2) ? $urandom : 32'($urandom % 32'h30000);
            case ($urandom % 4)
                0: ofs = lim - 32'($urandom % 10);
                1: ofs = 32'h0000FFF8 + 32'($urandom % 12);
                2: ofs = 32'hFFFFFFF8 + 32'($urandom % 8);
                default: ofs = $urandom;
            endcase
            sz = ($urandom % 8 == 0) ? 4'($urandom) : 4'(1 << ($urandom % 4));
            run("random", m, 3'($urandom), ofs, sz, lim,
                ($urandom % 5) != 0, ($urandom % 5) != 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule